// File: doc/BRIEF.md
# Spike-Driven Plasticity Weight Updater

This block updates the weight of one excitatory synapse per clock for a spiking network that advances in discrete simulation steps. For every synapse of a postsynaptic cell it takes the presynaptic spike bit for the current step, a teaching spike bit shared by that postsynaptic cell, and the stored weight and presynaptic activity trace words for the synapse. It returns the new weight and the new trace, which the surrounding logic writes back to its own storage.

The trace is a first-order low-pass filter of presynaptic firing. Each step it is multiplied by a programmable decay factor, rounded stochastically using a free-running LFSR, and raised by a programmable input gain when the presynaptic cell fired. When the teaching cell spikes, the weight is lowered by the freshly updated trace (depression). When the presynaptic cell fires while the teaching cell is silent, the weight is raised by a programmable fixed step (potentiation). All words are 16-bit unsigned fixed point. Weights saturate at zero and at a full-scale code that stands for 1.0, and never wrap. The datapath is a three-stage pipeline that accepts a new synapse on every clock.

Top module: `plast_weight_updater`

## Requirements
- R1: While rst_ni is low, and on the first three clock edges after it rises with no valid input, valid_o is 0 and weight_o and trace_o are 0.
- R2: A synapse presented with valid_i=1 at a rising edge appears on the outputs with valid_o=1 three rising edges later. Synapses may be presented on consecutive clocks, and each keeps its own order and result.
- R3: The decayed trace is floor(trace_i*trace_decay_i/65536) or that value plus 1, where trace_decay_i is unsigned Q0.16. The rounding is up exactly when a pseudo-random 16-bit value is below the discarded 16-bit fraction, so a zero fraction is exact, and a non-zero fraction yields both results over repeated steps.
- R4: When pre_spike_i is 1, trace_o is the decayed trace plus trace_gain_i, saturated at 0xFFFF. When pre_spike_i is 0, no gain is added.
- R5: When teach_spike_i is 1, weight_o equals weight_i minus trace_o, clamped at 0.
- R6: When pre_spike_i is 1 and teach_spike_i is 0, weight_o equals weight_i plus ltp_step_i, clamped at the full-scale code W_MAX (default 0xFFFF).
- R7: When both spike bits are 0, weight_o equals weight_i.
- R8: When both spike bits are 1, only depression applies: no potentiation step is added.
- R9: The weight never wraps: depression never raises it and potentiation never lowers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trace_decay_i | input | 16 | Trace decay factor, unsigned Q0.16 |
| trace_gain_i | input | 16 | Trace increment on presynaptic spike |
| ltp_step_i | input | 16 | Potentiation step |
| valid_i | input | 1 | Synapse present on the inputs |
| pre_spike_i | input | 1 | Presynaptic spike in this step |
| teach_spike_i | input | 1 | Teaching spike in this step |
| weight_i | input | 16 | Stored weight of the synapse |
| trace_i | input | 16 | Stored presynaptic trace of the synapse |
| valid_o | output | 1 | Result present on the outputs |
| weight_o | output | 16 | Updated weight |
| trace_o | output | 16 | Updated trace |

## Verification
The four spike-bit combinations are each applied with a decay factor of one half and even traces, so the rounding is exact and hold, potentiation, depression and the both-spikes case are told apart by exact weights. Weights near zero and near full scale with large steps or traces separate clamping from wrapping, and a trace near full scale with a gain separates saturation from overflow. A decay factor with a non-zero fraction is repeated on one synapse to show that results stay within one code of the exact product and that rounding goes both ways, which catches plain truncation. A back-to-back stream of mixed synapses shows that results keep their order and their three-clock latency.

// File: rtl/plast_pkg.sv
package plast_pkg;

  typedef enum logic [1:0] {
    RULE_HOLD = 2'd0,
    RULE_LTP  = 2'd1,
    RULE_LTD  = 2'd2
  } plast_rule_e;

  localparam int unsigned PL_DW     = 16;
  localparam int unsigned PL_LFSR_W = 32;

endpackage

// File: rtl/plast_lfsr.sv
module plast_lfsr #(
  parameter int unsigned          W     = 32,
  parameter int unsigned          OUT_W = 16,
  parameter logic [W-1:0]         TAPS  = 32'h8020_0003,
  parameter logic [W-1:0]         SEED  = 32'hACE1_2468
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] rnd_o
);

  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  // Galois form, right shift
  always_comb begin
    state_d = state_q >> 1;
    if (state_q[0]) state_d = state_d ^ TAPS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign rnd_o = state_q[OUT_W-1:0];

endmodule

// File: rtl/plast_trace_stage.sv
module plast_trace_stage
  import plast_pkg::*;
#(
  parameter int unsigned DW = PL_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] decay_i,
  input  logic [DW-1:0] gain_i,
  input  logic [DW-1:0] rnd_i,
  input  logic          valid_i,
  input  logic          pre_i,
  input  logic          teach_i,
  input  logic [DW-1:0] weight_i,
  input  logic [DW-1:0] trace_i,
  output logic          valid_o,
  output plast_rule_e   rule_o,
  output logic [DW-1:0] weight_o,
  output logic [DW-1:0] trace_o
);

  localparam int unsigned PW = 2 * DW;
  localparam logic [DW:0] SAT_MAX = {1'b0, {DW{1'b1}}};

  logic [PW-1:0] prod;
  logic [DW-1:0] prod_int;
  logic [DW-1:0] prod_frac;
  logic          round_up;
  logic [DW:0]   decayed;
  logic [DW:0]   raised;
  logic [DW-1:0] trace_d;
  plast_rule_e   rule_d;

  always_comb begin
    prod      = PW'(trace_i) * PW'(decay_i);
    prod_int  = prod[PW-1:DW];
    prod_frac = prod[DW-1:0];
    // round up when the random draw falls below the fraction
    round_up  = (rnd_i < prod_frac);
    decayed   = {1'b0, prod_int} + {{DW{1'b0}}, round_up};
    raised    = decayed + (pre_i ? {1'b0, gain_i} : '0);
    trace_d   = (raised > SAT_MAX) ? {DW{1'b1}} : raised[DW-1:0];
  end

  always_comb begin
    if (teach_i)    rule_d = RULE_LTD;
    else if (pre_i) rule_d = RULE_LTP;
    else            rule_d = RULE_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      rule_o   <= RULE_HOLD;
      weight_o <= '0;
      trace_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        rule_o   <= rule_d;
        weight_o <= weight_i;
        trace_o  <= trace_d;
      end
    end
  end

endmodule

// File: rtl/plast_delta_stage.sv
module plast_delta_stage
  import plast_pkg::*;
#(
  parameter int unsigned DW = PL_DW
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [DW-1:0]       step_i,
  input  logic                valid_i,
  input  plast_rule_e         rule_i,
  input  logic [DW-1:0]       weight_i,
  input  logic [DW-1:0]       trace_i,
  output logic                valid_o,
  output logic signed [DW+1:0] sum_o,
  output logic [DW-1:0]       trace_o
);

  localparam int unsigned SW = DW + 2;

  logic signed [SW-1:0] w_ext;
  logic signed [SW-1:0] t_ext;
  logic signed [SW-1:0] s_ext;
  logic signed [SW-1:0] sum_d;

  always_comb begin
    w_ext = signed'({2'b00, weight_i});
    t_ext = signed'({2'b00, trace_i});
    s_ext = signed'({2'b00, step_i});
    unique case (rule_i)
      RULE_LTD: sum_d = w_ext - t_ext;
      RULE_LTP: sum_d = w_ext + s_ext;
      default:  sum_d = w_ext;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sum_o   <= '0;
      trace_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sum_o   <= sum_d;
        trace_o <= trace_i;
      end
    end
  end

endmodule

// File: rtl/plast_clamp_stage.sv
module plast_clamp_stage
  import plast_pkg::*;
#(
  parameter int unsigned   DW    = PL_DW,
  parameter logic [DW-1:0] W_MAX = {DW{1'b1}}
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic signed [DW+1:0] sum_i,
  input  logic [DW-1:0]        trace_i,
  output logic                 valid_o,
  output logic [DW-1:0]        weight_o,
  output logic [DW-1:0]        trace_o
);

  localparam logic signed [DW+1:0] HI = signed'({2'b00, W_MAX});

  logic [DW-1:0] weight_d;

  always_comb begin
    if (sum_i < 0)       weight_d = '0;
    else if (sum_i > HI) weight_d = W_MAX;
    else                 weight_d = sum_i[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      weight_o <= '0;
      trace_o  <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        weight_o <= weight_d;
        trace_o  <= trace_i;
      end
    end
  end

endmodule

// File: rtl/plast_weight_updater.sv
module plast_weight_updater
  import plast_pkg::*;
#(
  parameter int unsigned          DW        = PL_DW,
  parameter logic [DW-1:0]        W_MAX     = {DW{1'b1}},
  parameter int unsigned          LFSR_W    = PL_LFSR_W,
  parameter logic [LFSR_W-1:0]    LFSR_TAPS = 32'h8020_0003,
  parameter logic [LFSR_W-1:0]    LFSR_SEED = 32'hACE1_2468
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] trace_decay_i,
  input  logic [DW-1:0] trace_gain_i,
  input  logic [DW-1:0] ltp_step_i,
  input  logic          valid_i,
  input  logic          pre_spike_i,
  input  logic          teach_spike_i,
  input  logic [DW-1:0] weight_i,
  input  logic [DW-1:0] trace_i,
  output logic          valid_o,
  output logic [DW-1:0] weight_o,
  output logic [DW-1:0] trace_o
);

  logic [DW-1:0]        rnd;
  logic                 s1_valid;
  plast_rule_e          s1_rule;
  logic [DW-1:0]        s1_weight;
  logic [DW-1:0]        s1_trace;
  logic                 s2_valid;
  logic signed [DW+1:0] s2_sum;
  logic [DW-1:0]        s2_trace;

  plast_lfsr #(
    .W     (LFSR_W),
    .OUT_W (DW),
    .TAPS  (LFSR_TAPS),
    .SEED  (LFSR_SEED)
  ) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rnd_o  (rnd)
  );

  plast_trace_stage #(.DW(DW)) u_trace (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .decay_i  (trace_decay_i),
    .gain_i   (trace_gain_i),
    .rnd_i    (rnd),
    .valid_i  (valid_i),
    .pre_i    (pre_spike_i),
    .teach_i  (teach_spike_i),
    .weight_i (weight_i),
    .trace_i  (trace_i),
    .valid_o  (s1_valid),
    .rule_o   (s1_rule),
    .weight_o (s1_weight),
    .trace_o  (s1_trace)
  );

  plast_delta_stage #(.DW(DW)) u_delta (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (ltp_step_i),
    .valid_i  (s1_valid),
    .rule_i   (s1_rule),
    .weight_i (s1_weight),
    .trace_i  (s1_trace),
    .valid_o  (s2_valid),
    .sum_o    (s2_sum),
    .trace_o  (s2_trace)
  );

  plast_clamp_stage #(.DW(DW), .W_MAX(W_MAX)) u_clamp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (s2_valid),
    .sum_i    (s2_sum),
    .trace_i  (s2_trace),
    .valid_o  (valid_o),
    .weight_o (weight_o),
    .trace_o  (trace_o)
  );

endmodule

// File: rtl/plast_chk.sv
module plast_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          pre_spike_i,
  input logic          teach_spike_i,
  input logic [DW-1:0] weight_i,
  input logic [DW-1:0] trace_i,
  input logic          valid_o,
  input logic [DW-1:0] weight_o,
  input logic [DW-1:0] trace_o
);

  logic [1:0] age_q;
  logic       armed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             age_q <= '0;
    else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
  end

  assign armed = (age_q == 2'd3);

  p_quiet_after_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed |-> !valid_o);

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> (valid_o == $past(valid_i, 3)));

  p_trace_no_growth_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o && !$past(pre_spike_i, 3)) |-> (trace_o <= $past(trace_i, 3)));

  p_depress_no_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o && $past(teach_spike_i, 3)) |-> (weight_o <= $past(weight_i, 3)));

  p_potentiate_no_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o && $past(pre_spike_i, 3) && !$past(teach_spike_i, 3))
      |-> (weight_o >= $past(weight_i, 3)));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed && valid_o && !$past(pre_spike_i, 3) && !$past(teach_spike_i, 3))
      |-> (weight_o == $past(weight_i, 3)));

endmodule

bind plast_weight_updater plast_chk #(.DW(DW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .valid_i       (valid_i),
  .pre_spike_i   (pre_spike_i),
  .teach_spike_i (teach_spike_i),
  .weight_i      (weight_i),
  .trace_i       (trace_i),
  .valid_o       (valid_o),
  .weight_o      (weight_o),
  .trace_o       (trace_o)
);

// File: tb/sim_plast_weight_updater.sv
`timescale 1ns/1ps
module sim_plast_weight_updater;

  localparam int unsigned DW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] trace_decay_i = 16'h8000;
  logic [DW-1:0] trace_gain_i  = 16'h0040;
  logic [DW-1:0] ltp_step_i    = 16'h0200;
  logic          valid_i = 1'b0;
  logic          pre_spike_i = 1'b0;
  logic          teach_spike_i = 1'b0;
  logic [DW-1:0] weight_i = '0;
  logic [DW-1:0] trace_i = '0;
  logic          valid_o;
  logic [DW-1:0] weight_o;
  logic [DW-1:0] trace_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic          got_v;
  logic [DW-1:0] got_w;
  logic [DW-1:0] got_t;

  always #2.5 clk_i = ~clk_i;

  plast_weight_updater u0 (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .trace_decay_i (trace_decay_i),
    .trace_gain_i  (trace_gain_i),
    .ltp_step_i    (ltp_step_i),
    .valid_i       (valid_i),
    .pre_spike_i   (pre_spike_i),
    .teach_spike_i (teach_spike_i),
    .weight_i      (weight_i),
    .trace_i       (trace_i),
    .valid_o       (valid_o),
    .weight_o      (weight_o),
    .trace_o       (trace_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input logic [31:0] act,
                         input logic [31:0] lo, input logic [31:0] hi);
    n_cmp++;
    if (act < lo || act > hi) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h..%h", req, act, lo, hi);
    end
  endtask

  // one synapse through the pipe, results captured after the third edge
  task automatic apply(input logic pre, input logic teach,
                       input logic [DW-1:0] w, input logic [DW-1:0] t);
    @(negedge clk_i);
    valid_i = 1'b1; pre_spike_i = pre; teach_spike_i = teach;
    weight_i = w; trace_i = t;
    @(negedge clk_i);
    valid_i = 1'b0; pre_spike_i = 1'b0; teach_spike_i = 1'b0;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    got_v = valid_o; got_w = weight_o; got_t = trace_o;
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1 valid in reset", 32'(valid_o), 0);
    chk("R1 weight in reset", 32'(weight_o), 0);
    chk("R1 trace in reset", 32'(trace_o), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 valid idle after reset", 32'(valid_o), 0);
    chk("R1 weight idle after reset", 32'(weight_o), 0);
  endtask

  task automatic t_hold;
    trace_decay_i = 16'h8000;
    apply(1'b0, 1'b0, 16'h1234, 16'h0100);
    chk("R2 valid after 3 edges", 32'(got_v), 1);
    chk("R7 weight held", 32'(got_w), 32'h1234);
    chk("R4 no gain without spike", 32'(got_t), 32'h0080);
  endtask

  task automatic t_potentiate;
    trace_decay_i = 16'h8000; trace_gain_i = 16'h0040; ltp_step_i = 16'h0200;
    apply(1'b1, 1'b0, 16'h1000, 16'h0200);
    chk("R4 trace gain", 32'(got_t), 32'h0140);
    chk("R6 potentiation step", 32'(got_w), 32'h1200);
    apply(1'b1, 1'b0, 16'hFF00, 16'h0000);
    chk("R6 clamp at full scale", 32'(got_w), 32'hFFFF);
    ltp_step_i = 16'hFFFF;
    apply(1'b1, 1'b0, 16'hFFFF, 16'h0000);
    chk("R9 no wrap upward", 32'(got_w), 32'hFFFF);
    ltp_step_i = 16'h0200;
  endtask

  task automatic t_trace_sat;
    trace_decay_i = 16'hFFFF; trace_gain_i = 16'h0100;
    apply(1'b1, 1'b0, 16'h0000, 16'hFFFE);
    chk("R4 trace saturates", 32'(got_t), 32'hFFFF);
    trace_gain_i = 16'h0040;
  endtask

  task automatic t_depress;
    trace_decay_i = 16'h8000;
    apply(1'b0, 1'b1, 16'h3000, 16'h0400);
    chk("R5 depression trace", 32'(got_t), 32'h0200);
    chk("R5 depression weight", 32'(got_w), 32'h2E00);
    apply(1'b0, 1'b1, 16'h0100, 16'h0800);
    chk("R5 clamp at zero", 32'(got_w), 0);
    trace_decay_i = 16'hFFFF;
    apply(1'b0, 1'b1, 16'h0001, 16'hFFFE);
    chk("R9 no wrap downward", 32'(got_w), 0);
    trace_decay_i = 16'h8000;
  endtask

  task automatic t_both;
    trace_decay_i = 16'h8000; trace_gain_i = 16'h0040; ltp_step_i = 16'h0200;
    apply(1'b1, 1'b1, 16'h3000, 16'h0400);
    chk("R8 both spikes trace", 32'(got_t), 32'h0240);
    chk("R8 depression only", 32'(got_w), 32'h2DC0);
  endtask

  task automatic t_rounding;
    logic [31:0] prod;
    int ups;
    int downs;
    trace_decay_i = 16'hF5C3;
    for (int k = 0; k < 3; k++) begin
      logic [15:0] t;
      t = 16'h1234 + 16'(k * 16'h0731);
      prod = 32'(t) * 32'(trace_decay_i);
      apply(1'b0, 1'b0, 16'h0AAA, t);
      chk_rng("R3 decay within one code", 32'(got_t), 32'(prod[31:16]), 32'(prod[31:16]) + 1);
      chk("R7 weight held while decaying", 32'(got_w), 32'h0AAA);
    end
    trace_decay_i = 16'h8000;
    ups = 0; downs = 0;
    for (int k = 0; k < 24; k++) begin
      apply(1'b0, 1'b0, 16'h0000, 16'h0003);
      if (got_t == 16'h0002) ups++;
      else if (got_t == 16'h0001) downs++;
    end
    chk("R3 rounding results in range", 32'(ups + downs), 24);
    chk("R3 rounding goes up sometimes", 32'(ups > 0), 1);
    chk("R3 rounding goes down sometimes", 32'(downs > 0), 1);
  endtask

  task automatic t_stream;
    logic        s_pre[4]   = '{1'b1, 1'b0, 1'b0, 1'b1};
    logic        s_teach[4] = '{1'b0, 1'b1, 1'b0, 1'b1};
    logic [15:0] s_w[4]     = '{16'h0100, 16'h0500, 16'h0777, 16'h0010};
    logic [15:0] s_t[4]     = '{16'h0010, 16'h0100, 16'h0002, 16'h0100};
    logic [15:0] e_w[4]     = '{16'h0300, 16'h0480, 16'h0777, 16'h0000};
    logic [15:0] e_t[4]     = '{16'h0048, 16'h0080, 16'h0001, 16'h00C0};
    trace_decay_i = 16'h8000; trace_gain_i = 16'h0040; ltp_step_i = 16'h0200;
    for (int c = 0; c < 8; c++) begin
      @(negedge clk_i);
      if (c >= 3 && c < 7) begin
        chk("R2 stream valid", 32'(valid_o), 1);
        chk("R2 stream weight", 32'(weight_o), 32'(e_w[c-3]));
        chk("R2 stream trace", 32'(trace_o), 32'(e_t[c-3]));
      end
      if (c == 7) chk("R2 valid drops after stream", 32'(valid_o), 0);
      if (c < 4) begin
        valid_i = 1'b1; pre_spike_i = s_pre[c]; teach_spike_i = s_teach[c];
        weight_i = s_w[c]; trace_i = s_t[c];
      end else begin
        valid_i = 1'b0; pre_spike_i = 1'b0; teach_spike_i = 1'b0;
      end
    end
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    t_reset();
    t_hold();
    t_potentiate();
    t_trace_sat();
    t_depress();
    t_both();
    t_rounding();
    t_stream();
    repeat (2) @(negedge clk_i);
    done = 1'b1;
    report();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      report();
    end
  end

endmodule